// File: doc/BRIEF.md
# Event Statistics Counter Bank

This block keeps a bank of wide event counters and presents them on a narrow register bus. Each used slot has its own strobe input. A strobe is high for one clock per event, and the slot adds one on every clock where its strobe is high. Slots beyond the used range exist in the address map but hold no counter, and they read as zero.

One bus-writable control word drives the whole bank. One bit freezes counting, and events that arrive while it is set are dropped. Another bit forces every counter to zero for as long as it stays set.

A counter is wider than the bus, so software reads it in two halves at neighbouring word addresses. Reading the lower half copies the upper half into a shadow register. A following read of that same counter's upper half returns the shadow, so the two halves belong to one moment even if events keep arriving between the reads.

Top module: `evstat_bank`

## Requirements
- R1: After synchronous reset, every counter, both control bits and the read data output are zero.
- R2: Slots 0 to 13 each add exactly one per clock in which their strobe is high, while neither freeze nor clear is set. Without a strobe, a slot keeps its value.
- R3: Counter n occupies word addresses 0x0080+2n (bits 15:0) and 0x0081+2n (bits 31:16).
- R4: While control bit 7 (clear) is 1, all counters read zero, and an event in the same clock as an active clear leaves the counter at zero. Counting resumes after software writes 0 to the bit.
- R5: While control bit 8 (freeze) is 1 and clear is 0, no counter changes and strobes are lost. After the bit returns to 0, counting resumes.
- R6: The control word at address 0x0000 reads back bits 7 and 8 as last written. Bits 15:9 and 6:0 ignore writes and read 0. The control bits change only on a write to address 0x0000.
- R7: Slots 14 and 15 always read zero in both halves.
- R8: A read of a counter's upper half returns the upper bits captured by the latest lower-half read, if that read addressed the same counter and no other upper-half read came between them. Otherwise it returns the live upper bits.
- R9: Read data is registered. It appears after the clock edge where the read strobe is sampled, and it holds until the next read. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | 14 | One event strobe per used slot, bit n feeds slot n |
| reg_addr | input | 16 | Word address for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |

## Verification
A write of the control word takes effect on the clock edge that samples it. The counters see the new clear or freeze from the next edge on. The bench therefore updates its reference model for events only from the edge after a control write returns. That includes the edge of the write itself, where a strobe still counts. Read data is due one edge after the read strobe is sampled. The bench drives the address and strobe at a falling edge and reads the result at the following falling edge, and it keeps the strobes low during reads so that every comparison uses a settled count.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_LO, SEL_HI} rd_sel_e;
endpackage

// File: rtl/evstat_ctrl.sv
module evstat_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int BUS_W     = 16,
  parameter int CTRL_ADDR = 0,
  parameter int CLR_BIT   = 7,
  parameter int FRZ_BIT   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] ctrl_word,
  output logic             clr,
  output logic             frz
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [BUS_W-1:0]  KEEP   = (BUS_W'(1) << CLR_BIT) | (BUS_W'(1) << FRZ_BIT);

  logic hit;
  assign hit = wr && (addr == CTRL_A);

  always_ff @(posedge clk) begin
    if (rst)      ctrl_word <= '0;
    else if (hit) ctrl_word <= wdata & KEEP;
  end

  assign clr = ctrl_word[CLR_BIT];
  assign frz = ctrl_word[FRZ_BIT];

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(ctrl_word));
endmodule

// File: rtl/evstat_counter.sv
module evstat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev,
  input  logic             clr,
  input  logic             frz,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (ev && !frz) cnt <= cnt + 1'b1;
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R5
  frz_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (frz && !clr) |=> $stable(cnt));
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev && !clr) |=> $stable(cnt));
endmodule

// File: rtl/evstat_rdmux.sv
module evstat_rdmux
  import evstat_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BUS_W     = 16,
  parameter int CNT_W     = 32,
  parameter int N_SLOTS   = 16,
  parameter int BASE_ADDR = 'h80,
  parameter int CTRL_ADDR = 0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [BUS_W-1:0]               ctrl_word,
  input  logic [N_SLOTS-1:0][CNT_W-1:0]  cnts,
  output logic [BUS_W-1:0]               rdata
);
  localparam int HI_W  = CNT_W - BUS_W;
  localparam int IDX_W = $clog2(N_SLOTS);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_ADDR + 2 * N_SLOTS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  rd_sel_e           sel;
  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  idx;
  logic [HI_W-1:0]   shadow;
  logic [IDX_W-1:0]  sh_idx;
  logic              sh_ok;

  always_comb begin
    offs = addr - BASE_A;
    idx  = offs[IDX_W:1];
    if (addr == CTRL_A)                      sel = SEL_CTRL;
    else if (addr >= BASE_A && addr < END_A) sel = offs[0] ? SEL_HI : SEL_LO;
    else                                     sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      shadow <= '0;
      sh_idx <= '0;
      sh_ok  <= 1'b0;
    end else if (rd) begin
      case (sel)
        SEL_CTRL: rdata <= ctrl_word;
        SEL_LO: begin
          rdata  <= cnts[idx][BUS_W-1:0];
          shadow <= cnts[idx][CNT_W-1:BUS_W];
          sh_idx <= idx;
          sh_ok  <= 1'b1;
        end
        SEL_HI: begin
          rdata <= (sh_ok && sh_idx == idx) ? BUS_W'(shadow)
                                            : BUS_W'(cnts[idx][CNT_W-1:BUS_W]);
          sh_ok <= 1'b0;
        end
        default: rdata <= '0;
      endcase
    end
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/evstat_bank.sv
module evstat_bank #(
  parameter int N_SLOTS   = 16,
  parameter int N_EVENTS  = 14,
  parameter int CNT_W     = 32,
  parameter int BUS_W     = 16,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'h80,
  parameter int CTRL_ADDR = 0,
  parameter int CLR_BIT   = 7,
  parameter int FRZ_BIT   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EVENTS-1:0] ev_strobe,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [BUS_W-1:0]    reg_wdata,
  input  logic                reg_rd,
  output logic [BUS_W-1:0]    reg_rdata
);
  logic [BUS_W-1:0]              ctrl_word;
  logic                          clr, frz;
  logic [N_SLOTS-1:0][CNT_W-1:0] cnts;

  evstat_ctrl #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CTRL_ADDR(CTRL_ADDR),
                .CLR_BIT(CLR_BIT), .FRZ_BIT(FRZ_BIT)) ctrl_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_word(ctrl_word), .clr(clr), .frz(frz));

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    if (g < N_EVENTS) begin : g_cnt
      evstat_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .ev(ev_strobe[g]), .clr(clr), .frz(frz),
        .cnt(cnts[g]));
    end else begin : g_empty
      assign cnts[g] = '0;
    end
  end

  evstat_rdmux #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W),
                 .N_SLOTS(N_SLOTS), .BASE_ADDR(BASE_ADDR),
                 .CTRL_ADDR(CTRL_ADDR)) rdmux_i (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
    .ctrl_word(ctrl_word), .cnts(cnts), .rdata(reg_rdata));

  // R7
  empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cnts[N_SLOTS-1] == '0));
endmodule

// File: tb/evstat_bank_tb.sv
`timescale 1ns/1ps
module evstat_bank_tb_top;
  localparam int NS = 16;
  localparam int NE = 14;
  // stimulus: {event mask, cycles}; mask is ANDed with a bench LFSR each cycle
  localparam logic [21:0] STIM [6] = '{
    {14'h3FFF, 8'd7}, {14'h0001, 8'd20}, {14'h2AAA, 8'd33},
    {14'h1555, 8'd12}, {14'h3FFF, 8'd60}, {14'h2001, 8'd9}};

  logic clk = 0, rst = 1;
  logic [NE-1:0] ev = '0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic wr = 0, rd = 0;
  int total = 0, bad = 0;
  longint model [NS];
  bit frz_m = 0, clr_m = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  evstat_bank dut_i (.clk(clk), .rst(rst), .ev_strobe(ev), .reg_addr(addr),
    .reg_wr(wr), .reg_wdata(wdata), .reg_rd(rd), .reg_rdata(rdata));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_word(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic wr_word(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(posedge clk);
    for (int s = 0; s < NE; s++) if (ev[s] && !frz_m && !clr_m) model[s]++;
    @(negedge clk); wr = 0;
    clr_m = d[7]; frz_m = d[8];
    if (clr_m) for (int s = 0; s < NS; s++) model[s] = 0;
  endtask

  task automatic run_ev(input logic [NE-1:0] mask, input int n, input bit rnd);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev = rnd ? (mask & lfsr[NE-1:0]) : mask;
      @(posedge clk);
      for (int s = 0; s < NE; s++) if (ev[s] && !frz_m && !clr_m) model[s]++;
    end
    @(negedge clk); ev = '0;
  endtask

  task automatic chk_slot(input int n, input string tag);
    logic [15:0] lo, hi;
    logic [31:0] e;
    e = (n < NE) ? model[n][31:0] : 32'h0;
    rd_word(16'h0080 + 16'(2 * n), lo);
    rd_word(16'h0081 + 16'(2 * n), hi);
    chk(tag, lo, e[15:0]);
    chk(tag, hi, e[31:16]);
  endtask

  task automatic chk_all(input string tag);
    for (int n = 0; n < NS; n++) chk_slot(n, tag);
  endtask

  initial begin
    #1_900_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d, hold;
    for (int s = 0; s < NS; s++) model[s] = 0;
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", rdata, 16'h0);
    rst = 0;
    rd_word(16'h0000, d); chk("R1 ctrl after reset", d, 16'h0);
    chk_slot(0, "R1 slot0 after reset");

    // table walk: random strobes, split reads of every slot (R2 R3 R7)
    for (int i = 0; i < 6; i++) begin
      run_ev(STIM[i][21:8], int'(STIM[i][7:0]), 1'b1);
      chk_all("R2 R3 R7 table");
    end

    // freeze (R5)
    wr_word(16'h0000, 16'h0100);
    rd_word(16'h0000, d); chk("R6 ctrl freeze readback", d, 16'h0100);
    run_ev(14'h3FFF, 20, 1'b0);
    chk_all("R5 frozen");
    wr_word(16'h0000, 16'h0000);
    run_ev(14'h3FFF, 3, 1'b0);
    chk_all("R5 after release");

    // reserved bits ignored, clear held (R6 R4)
    wr_word(16'h0000, 16'hFFFF);
    rd_word(16'h0000, d); chk("R6 reserved ignored", d, 16'h0180);
    chk_all("R4 clear with freeze");
    wr_word(16'h0000, 16'h0080);
    run_ev(14'h3FFF, 5, 1'b0);
    chk_all("R4 clear beats events");
    wr_word(16'h0000, 16'h0000);
    run_ev(14'h3FFF, 4, 1'b0);

    // clear asserted while strobes keep running (R4)
    @(negedge clk); ev = 14'h3FFF;
    wr_word(16'h0000, 16'h0080);
    run_ev(14'h3FFF, 3, 1'b0);
    chk_all("R4 clear during increment");
    wr_word(16'h0000, 16'h0000);
    run_ev(14'h3FFF, 2, 1'b0);
    chk_all("R4 counting after clear release");

    // unmapped and hold (R9)
    rd_word(16'h0001, d); chk("R9 unmapped 0x0001", d, 16'h0);
    rd_word(16'h00A0, d); chk("R9 unmapped 0x00A0", d, 16'h0);
    rd_word(16'h0080, hold);
    run_ev(14'h0001, 4, 1'b0);
    chk("R9 rdata holds without read", rdata, hold);

    // shadow coherence on slot 2 (R8)
    wr_word(16'h0000, 16'h0080);
    wr_word(16'h0000, 16'h0000);
    run_ev(14'h0004, 65530, 1'b0);
    rd_word(16'h0084, d); chk("R8 low before carry", d, 16'hFFFA);
    run_ev(14'h0004, 10, 1'b0);
    rd_word(16'h0085, d); chk("R8 high from shadow", d, 16'h0000);
    rd_word(16'h0084, d); chk("R3 low after carry", d, 16'h0004);
    rd_word(16'h0085, d); chk("R3 high after carry", d, 16'h0001);
    rd_word(16'h008A, d);
    rd_word(16'h0085, d); chk("R8 high live on other slot", d, 16'h0001);
    chk_slot(14, "R7 slot14");
    chk_slot(15, "R7 slot15");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule